// File: doc/BRIEF.md
# Debug Trace Buffer Fill Counter

This block keeps track of how much of an on-chip debug trace buffer holds valid data. The buffer stores 64 lines of 64 bits, and the capture logic writes each line as two 32-bit halves. Every accepted half-write strobe advances a 7-bit count by one, so the count is expressed in half-line units. When the count wraps from its top value back to zero, a sticky full flag is raised. From then on, a count of zero together with the flag means that every line is valid.

What happens at the wrap depends on the trigger alignment. With end or mid alignment, capture keeps going and the newest lines overwrite the oldest. With begin alignment, the session ends at the wrap. The block sends a one-cycle request to clear the software arm bit and takes no further strobes until the arm bit is written again. Writing a one to the arm bit restarts the count and the flag. Only power-on reset clears them. A system reset leaves both in place, so that software can still see after the reset how much was captured before it. Reading the buffer has no path into this block, so reading never lowers the count.

Top module: `trace_fill_counter`

## Requirements
- R1: While power-on reset `por_n` is low, `fill_count` reads 0, `buf_full` reads 0 and `arm_clr_req` reads 0. Assertion of `por_n` takes effect at once. Release takes effect after two clock edges.
- R2: A `half_wr` strobe sampled high on a clock edge while `arm` is high and the block is in normal operation raises `fill_count` by exactly one, modulo 128. The new value is visible after that edge.
- R3: A `half_wr` strobe sampled while `arm` is low changes neither `fill_count` nor `buf_full`.
- R4: A strobe accepted at count 127 makes the count 0 and sets `buf_full`. `buf_full` then stays set until `arm_wr1` or power-on reset.
- R5: With `align_mode` 2'b00 (end), 2'b01 (mid) or 2'b11 (treated as end), accepted strobes keep advancing the count after a wrap, and `arm_clr_req` stays low.
- R6: With `align_mode` 2'b10 (begin), the wrap raises `arm_clr_req` for exactly one cycle, in the cycle in which the count first reads 0 with `buf_full` set. After that, no strobe changes the count until `arm_wr1`, even if `arm` stays high.
- R7: `arm_wr1` sampled high clears `fill_count` and `buf_full` to 0 on that edge. It takes priority over a strobe in the same cycle and re-enables counting after a begin-mode stop.
- R8: While `sys_rst_n` is low, `fill_count` and `buf_full` keep their values and strobes are ignored. Assertion takes effect at once. Counting resumes two edges after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low |
| sys_rst_n | input | 1 | System reset, active low; count and flag survive it |
| arm | input | 1 | Current value of the software arm bit |
| arm_wr1 | input | 1 | One-cycle pulse: software wrote a one to the arm bit |
| half_wr | input | 1 | One 32-bit half-line written to the trace buffer |
| align_mode | input | 2 | Trigger alignment: 00 end, 01 mid, 10 begin, 11 end |
| fill_count | output | 7 | Valid data in half-line units |
| buf_full | output | 1 | Sticky flag: the count has wrapped |
| arm_clr_req | output | 1 | One-cycle request to clear the arm bit (begin mode) |

## Verification
The bench drives the count across the 127-to-0 boundary in every alignment. A counter that dropped the sticky flag, or that stopped in mid or end mode, would show the wrong count or flag right after the wrap. In begin mode it keeps the arm bit high after the stop request. A design that leaned on the arm bit alone, instead of latching the end of the session, would start counting from zero again. Two further cases are a system reset in the middle of a session, where a design that cleared its state would lose the count, and an arm write on the same edge as a strobe, where the wrong priority leaves the count at 1.

// File: rtl/fillcnt_pkg.sv
package fillcnt_pkg;

  typedef enum logic [1:0] {
    ALIGN_END   = 2'b00,
    ALIGN_MID   = 2'b01,
    ALIGN_BEGIN = 2'b10,
    ALIGN_RSVD  = 2'b11
  } align_e;

  // Only begin alignment stops at the wrap; the reserved code behaves as end.
  function automatic logic stops_on_wrap(input align_e mode);
    return (mode == ALIGN_BEGIN);
  endfunction

endpackage

// File: rtl/fillcnt_rst_sync.sv
module fillcnt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/fillcnt_counter.sv
module fillcnt_counter #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             clear_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             at_top_o,
  output logic             full_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             full_q, full_d;
  logic             cnt_en;

  assign at_top_o = &cnt_q;
  assign cnt_en   = clear_i | inc_i;

  always_comb begin
    cnt_d  = cnt_q;
    full_d = full_q;
    if (clear_i) begin
      cnt_d  = '0;
      full_d = 1'b0;
    end else if (inc_i) begin
      cnt_d = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
      if (at_top_o) full_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      full_q <= full_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign full_o = full_q;

endmodule

// File: rtl/fillcnt_ctrl.sv
module fillcnt_ctrl
  import fillcnt_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sys_ok_i,
  input  logic   arm_i,
  input  logic   arm_wr1_i,
  input  logic   half_wr_i,
  input  align_e mode_i,
  input  logic   at_top_i,
  output logic   inc_o,
  output logic   clear_o,
  output logic   arm_clr_o
);

  logic done_q, done_d;
  logic clr_q, clr_d;
  logic wrap_stop;

  assign clear_o   = arm_wr1_i;
  assign inc_o     = half_wr_i & arm_i & ~done_q & sys_ok_i & ~arm_wr1_i;
  assign wrap_stop = inc_o & at_top_i & stops_on_wrap(mode_i);

  always_comb begin
    done_d = done_q;
    if (arm_wr1_i)      done_d = 1'b0;
    else if (wrap_stop) done_d = 1'b1;
    clr_d = wrap_stop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      clr_q  <= clr_d;
    end
  end

  assign arm_clr_o = clr_q;

endmodule

// File: rtl/trace_fill_counter.sv
module trace_fill_counter
  import fillcnt_pkg::*;
#(
  parameter int LINES          = 64,
  parameter int HALVES_PER_LINE = 2,
  parameter int SYNC_STAGES    = 2,
  localparam int CNT_W         = $clog2(LINES * HALVES_PER_LINE)
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             sys_rst_n,
  input  logic             arm,
  input  logic             arm_wr1,
  input  logic             half_wr,
  input  logic [1:0]       align_mode,
  output logic [CNT_W-1:0] fill_count,
  output logic             buf_full,
  output logic             arm_clr_req
);

  logic   por_sync_n;
  logic   sys_sync_n;
  logic   inc;
  logic   clear;
  logic   at_top;
  align_e mode;

  assign mode = align_e'(align_mode);

  fillcnt_rst_sync #(.STAGES(SYNC_STAGES)) u_por_sync (
    .clk     (clk),
    .arst_n  (por_n),
    .rst_n_o (por_sync_n)
  );

  fillcnt_rst_sync #(.STAGES(SYNC_STAGES)) u_sys_sync (
    .clk     (clk),
    .arst_n  (sys_rst_n),
    .rst_n_o (sys_sync_n)
  );

  fillcnt_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (por_sync_n),
    .sys_ok_i  (sys_sync_n),
    .arm_i     (arm),
    .arm_wr1_i (arm_wr1),
    .half_wr_i (half_wr),
    .mode_i    (mode),
    .at_top_i  (at_top),
    .inc_o     (inc),
    .clear_o   (clear),
    .arm_clr_o (arm_clr_req)
  );

  fillcnt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (por_sync_n),
    .inc_i    (inc),
    .clear_i  (clear),
    .cnt_o    (fill_count),
    .at_top_o (at_top),
    .full_o   (buf_full)
  );

endmodule

// File: rtl/fillcnt_checker.sv
module fillcnt_checker #(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             por_n,
  input logic             sys_rst_n,
  input logic             arm,
  input logic             arm_wr1,
  input logic             half_wr,
  input logic [CNT_W-1:0] fill_count,
  input logic             buf_full,
  input logic             arm_clr_req
);

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!por_n)
    !arm_wr1 |=> (fill_count == $past(fill_count)) ||
                 (fill_count == $past(fill_count) + 1'b1)); // R2

  AST_IDLE_WHEN_DISARMED: assert property (@(posedge clk) disable iff (!por_n)
    (!arm && !arm_wr1) |=> ($stable(fill_count) && $stable(buf_full))); // R3

  AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    (buf_full && !arm_wr1) |=> buf_full); // R4

  AST_CLR_AT_WRAP: assert property (@(posedge clk) disable iff (!por_n)
    arm_clr_req |-> (buf_full && fill_count == '0)); // R6

  AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!por_n)
    arm_clr_req |=> !arm_clr_req); // R6

  AST_ARM_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
    arm_wr1 |=> (fill_count == '0 && !buf_full)); // R7

  AST_HOLD_IN_SYS_RESET: assert property (@(posedge clk) disable iff (!por_n)
    (!sys_rst_n && !arm_wr1) |=> ($stable(fill_count) && $stable(buf_full))); // R8

endmodule

bind trace_fill_counter fillcnt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .por_n       (por_n),
  .sys_rst_n   (sys_rst_n),
  .arm         (arm),
  .arm_wr1     (arm_wr1),
  .half_wr     (half_wr),
  .fill_count  (fill_count),
  .buf_full    (buf_full),
  .arm_clr_req (arm_clr_req)
);

// File: tb/trace_fill_counter_tb.sv
`timescale 1ns/1ps
module trace_fill_counter_tb;

  localparam time CLK_P = 4ns;

  logic       clk = 1'b0;
  logic       por_n, sys_rst_n, arm, arm_wr1, half_wr;
  logic [1:0] align_mode;
  logic [6:0] fill_count;
  logic       buf_full, arm_clr_req;

  int checks = 0;
  int fails  = 0;

  // reference model state
  int m_cnt;
  bit m_full, m_done, m_clr, m_sys_ok;
  bit pend_arm, auto_clr;

  always #(CLK_P/2) clk = ~clk;

  trace_fill_counter u_dut (
    .clk         (clk),
    .por_n       (por_n),
    .sys_rst_n   (sys_rst_n),
    .arm         (arm),
    .arm_wr1     (arm_wr1),
    .half_wr     (half_wr),
    .align_mode  (align_mode),
    .fill_count  (fill_count),
    .buf_full    (buf_full),
    .arm_clr_req (arm_clr_req)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(input string req);
    check({req, " count"}, int'(fill_count), m_cnt);
    check({req, " full"},  int'(buf_full),   int'(m_full));
    check({req, " clr"},   int'(arm_clr_req), int'(m_clr));
  endtask

  function automatic bit accepts(input bit s, input bit w);
    return s && arm && !m_done && m_sys_ok && !w;
  endfunction

  // One clock: drive at negedge, update model at posedge, check at next negedge.
  task automatic cycle(input bit s, input bit w, input string req);
    bit acc;
    if (m_clr && auto_clr) arm = 1'b0;
    if (pend_arm) begin arm = 1'b1; pend_arm = 1'b0; end
    half_wr = s;
    arm_wr1 = w;
    acc = accepts(s, w);
    @(posedge clk);
    if (w) begin
      m_cnt = 0; m_full = 0; m_done = 0; m_clr = 0;
    end else begin
      m_clr = 0;
      if (acc) begin
        if (m_cnt == 127) begin
          m_full = 1;
          if (align_mode == 2'b10) begin m_done = 1; m_clr = 1; end
        end
        m_cnt = (m_cnt + 1) % 128;
      end
    end
    pend_arm = w;
    @(negedge clk);
    half_wr = 1'b0;
    arm_wr1 = 1'b0;
    check_all(req);
  endtask

  task automatic do_por();
    @(negedge clk);
    por_n = 1'b0;
    arm = 1'b0; pend_arm = 0;
    half_wr = 1'b0; arm_wr1 = 1'b0;
    m_cnt = 0; m_full = 0; m_done = 0; m_clr = 0;
    #1;
    check_all("R1 por assert");
    @(negedge clk);
    @(negedge clk);
    por_n = 1'b1;
    for (int i = 0; i < 3; i++) cycle(1'b0, 1'b0, "R1 por release");
  endtask

  task automatic start(input logic [1:0] mode);
    align_mode = mode;
    cycle(1'b0, 1'b1, "R7 arm write");
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : stim
    por_n = 1'b0; sys_rst_n = 1'b1; arm = 1'b0; arm_wr1 = 1'b0;
    half_wr = 1'b0; align_mode = 2'b00;
    m_sys_ok = 1; auto_clr = 1; pend_arm = 0;
    m_cnt = 0; m_full = 0; m_done = 0; m_clr = 0;

    do_por();
    check("R1 reset count", int'(fill_count), 0);
    check("R1 reset full",  int'(buf_full), 0);

    // R3: strobes while disarmed
    for (int i = 0; i < 4; i++) cycle(1'b1, 1'b0, "R3 disarmed strobe");
    check("R3 count unchanged", int'(fill_count), 0);

    // R2: basic counting, end mode
    start(2'b00);
    for (int i = 0; i < 3; i++) cycle(1'b1, 1'b0, "R2 count");
    check("R2 three halves", int'(fill_count), 3);

    // R7: arm write with simultaneous strobe wins
    cycle(1'b1, 1'b1, "R7 priority");
    check("R7 priority count", int'(fill_count), 0);
    cycle(1'b1, 1'b0, "R2 after rearm");

    // R8: system reset retains and blocks
    for (int i = 0; i < 5; i++) cycle(1'b1, 1'b0, "R2 fill");
    sys_rst_n = 1'b0; m_sys_ok = 0;
    for (int i = 0; i < 4; i++) cycle(1'b1, 1'b0, "R8 in sys reset");
    check("R8 retained", int'(fill_count), 6);
    sys_rst_n = 1'b1;
    for (int i = 0; i < 3; i++) cycle(1'b0, 1'b0, "R8 release");
    m_sys_ok = 1;
    cycle(1'b1, 1'b0, "R8 resume");
    check("R8 resumed", int'(fill_count), 7);

    // R4/R5: mid mode wrap continues
    start(2'b01);
    for (int i = 0; i < 130; i++) cycle(1'b1, 1'b0, "R5 mid");
    check("R4 full set", int'(buf_full), 1);
    check("R5 mid continues", int'(fill_count), 2);

    // R5: reserved code acts as end
    start(2'b11);
    for (int i = 0; i < 129; i++) cycle(1'b1, 1'b0, "R5 rsvd");
    check("R5 rsvd continues", int'(fill_count), 1);

    // R6: begin mode stop, arm held high by software
    auto_clr = 0;
    start(2'b10);
    for (int i = 0; i < 127; i++) cycle(1'b1, 1'b0, "R6 begin fill");
    cycle(1'b1, 1'b0, "R6 wrap");
    check("R6 clr pulse", int'(arm_clr_req), 1);
    check("R6 count zero", int'(fill_count), 0);
    check("R4 full at wrap", int'(buf_full), 1);
    for (int i = 0; i < 6; i++) cycle(1'b1, 1'b0, "R6 stopped");
    check("R6 no increments", int'(fill_count), 0);
    check("R6 single pulse", int'(arm_clr_req), 0);
    start(2'b10);
    cycle(1'b1, 1'b0, "R7 rearm after stop");
    check("R7 counting again", int'(fill_count), 1);
    auto_clr = 1;

    // R1: power-on reset mid-session
    for (int i = 0; i < 9; i++) cycle(1'b1, 1'b0, "R2 fill");
    do_por();
    check("R1 por clears", int'(fill_count), 0);

    // random phase
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 6000; i++) begin
      bit s, w;
      s = ($urandom % 10) < 7;
      w = arm ? (($urandom % 400) == 0) : (($urandom % 20) == 0);
      if (w) align_mode = 2'($urandom % 4);
      if (!w && (($urandom % 500) == 0)) arm = 1'b0;
      cycle(s, w, "R2 R4 R5 R6 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule